// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block gathers interrupt sources for one processor and drives a single request line to it. Every source has its own enable, pending, active and trigger-style state and an 8-bit priority, where a smaller number means more urgent. An arbiter looks at every source that is both enabled and pending. When the winner is urgent enough against the priority mask and the priority of the handler now running, the block raises its request.

Software uses one memory-mapped word port, which has two register windows. The distributor window sets up the sources. The processor window gives the control bit, the mask, acknowledge, end-of-interrupt, the running priority and the highest pending ID. Each time an acknowledge succeeds, the ID that was running before is stored as the predecessor of the new source. This builds a chain, so nested handlers may finish in any order: a completion that names a source deeper in the chain removes that source from the chain and leaves the running handler in place. Level-sensitive sources become pending again at completion if their input is still high.

Top module: `nest_intc`

## Requirements
- R1: After reset: the highest pending ID and the running ID are 1023, which means none. The running priority reads 0x100, the mask reads 0xF0, and both enable bits are 0. Sources 0 to 14 are enabled and edge-triggered, so the enable word at 0x1100 reads 0x00007FFF and the configuration word at 0x1C00 reads 0x2AAAAAAA. The type word at 0x1004 reads NUM_SRC/32-1.
- R2: The highest pending ID (processor offset 0x18) is the enabled and pending source with the numerically lowest priority, with the lowest ID winning a tie. It reads 1023 when no source qualifies, when either enable bit is 0, or when the winner's priority is above the mask.
- R3: `irq_o` is high only when the distributor enable (0x1000 bit 0) and the processor enable (0x000 bit 0) are both set, the winner's priority is less than or equal to the mask (0x004), and it is strictly below the running priority.
- R4: Bit n of `ext_irq` drives source 32+n. A rising input sets pending if the source is edge-triggered or enabled. A falling input only updates the stored level and leaves pending as it is.
- R5: A read of 0x00C returns the highest pending ID when its priority is strictly below the running priority, and 1023 otherwise. On success it clears that source's pending bit, sets its active bit, makes it the running source with its priority, and drops `irq_o`.
- R6: Writing the running ID to 0x010 (low 10 bits) clears its active bit and makes its predecessor the running source again, or 1023 with priority 0x100 if it has none.
- R7: Writing a different ID that is in the chain to 0x010 clears its active bit and removes it from the predecessor chain. The running source does not change.
- R8: A write to 0x010 while the running ID is 1023 changes no state.
- R9: At end-of-interrupt, a source that is level-triggered, enabled and whose input is high becomes pending again.
- R10: Setting the enable of a level-triggered source whose input is high also sets its pending bit.
- R11: Distributor words hold 32 sources each, with bit b of word w standing for source 32w+b: set-enable 0x1100, clear-enable 0x1180, set-pending 0x1200, clear-pending 0x1280, active 0x1300 (read-only). Priorities are four per word from 0x1400, with source 4w+k in bits 8k+7:8k. Targets at 0x1800 read as zero. Configuration is sixteen per word from 0x1C00, with bit 2k holding the model and bit 2k+1 selecting edge for source 16w+k. Writing an ID to 0x1F00 sets that source pending.
- R12: An access to an unmapped offset returns zero data and raises `bus_err` for one cycle.
- R13: An access is accepted on a clock edge where `bus_valid` and `bus_ready` are both high. Read data appears with `bus_rvalid` on the following cycle. `bus_ready` is low for the cycle after any accepted access, after any input change, and for as long as a chain walk is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 13 | Byte address; bit 12 selects the distributor window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Block can accept an access |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after acceptance |
| bus_err | output | 1 | Unmapped access, one cycle after acceptance |
| ext_irq | input | NUM_SRC-32 | External interrupt inputs, bit n to source 32+n |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
On every cycle the assertions check the bus handshake. That covers the stall after an access and during a chain walk, read data following acceptance, and zero data with any error. They also check that the request never comes from a state with either enable off, that the highest pending ID is in range, and that an idle running ID goes with priority 0x100. Arbitration order, tie-breaking, mask and running-priority gating, acknowledge results, in-order and out-of-order completion, re-pending of level sources and the register layout can only be shown by the bench scenarios. Those include exhaustive single-source and pairwise sweeps with priorities computed by formula.

// File: rtl/nest_intc_pkg.sv
package nest_intc_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  typedef logic [ID_W-1:0]   src_id_t;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [PRIO_W:0]   rprio_t;   // one extra bit for the idle level
  localparam src_id_t ID_NONE   = src_id_t'(1023);
  localparam rprio_t  PRIO_IDLE = rprio_t'(9'h100);
endpackage

// File: rtl/nest_intc_arbiter.sv
module nest_intc_arbiter
  import nest_intc_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic [NUM_SRC-1:0] cand,
  input  prio_t              prio [NUM_SRC],
  output src_id_t            best_id,
  output rprio_t             best_prio
);
  // Ascending scan with strict compare: lowest value wins, ties go to lowest ID.
  always_comb begin
    best_id   = ID_NONE;
    best_prio = PRIO_IDLE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && ({1'b0, prio[i]} < best_prio)) begin
        best_id   = src_id_t'(i);
        best_prio = {1'b0, prio[i]};
      end
    end
  end
endmodule

// File: rtl/nest_intc_edge.sv
module nest_intc_edge #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  always_ff @(posedge clk) begin
    if (rst) lvl <= '0;
    else     lvl <= din;
  end
  assign rise = din & ~lvl;
  assign fall = ~din & lvl;
endmodule

// File: rtl/nest_intc.sv
module nest_intc
  import nest_intc_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [12:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic                bus_ready,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  output logic                bus_err,
  input  logic [NUM_SRC-33:0] ext_irq,
  output logic                irq_o
);
  localparam int NEXT  = NUM_SRC - 32;
  localparam int NWORD = NUM_SRC / 32;
  localparam int NPW   = NUM_SRC / 4;
  localparam int NCW   = NUM_SRC / 16;
  localparam int NBOOT = 15;

  logic [NUM_SRC-1:0] en_q, pend_q, act_q, model_q, edge_q;
  logic [NUM_SRC-1:0] n_en, n_pend, n_act, n_model, n_edge;
  prio_t   prio_q [NUM_SRC];
  prio_t   n_prio [NUM_SRC];
  src_id_t link_q [NUM_SRC];
  logic    dist_en_q, cpu_en_q, n_dist_en, n_cpu_en;
  prio_t   pmask_q, n_pmask;
  src_id_t run_id_q, n_run_id, hp_id_q, best_id;
  rprio_t  run_prio_q, n_run_prio, hp_prio_q, best_prio;
  logic    irq_q, dirty_q, walk_q, n_walk;
  src_id_t wtmp_q, wid_q, n_wtmp, n_wid;
  logic [31:0] rd_val;
  logic    rd_err, acc, ack_ok, link_we;
  src_id_t run_link, walk_next, wid_link;
  logic [NEXT-1:0]    lvl, rise, fall;
  logic [NUM_SRC-1:0] lvl_all;

  nest_intc_edge #(.W(NEXT)) edge_i (
    .clk(clk), .rst(rst), .din(ext_irq), .lvl(lvl), .rise(rise), .fall(fall));
  assign lvl_all = {lvl, 32'b0};

  nest_intc_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
    .cand(en_q & pend_q), .prio(prio_q), .best_id(best_id), .best_prio(best_prio));

  assign bus_ready = !dirty_q && !walk_q;
  assign acc       = bus_valid && bus_ready;
  assign irq_o     = irq_q;

  // Chain lookups by compare, so no index wider than the array is used.
  always_comb begin
    run_link = ID_NONE; walk_next = ID_NONE; wid_link = ID_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (run_id_q == src_id_t'(i)) run_link  = link_q[i];
      if (wtmp_q   == src_id_t'(i)) walk_next = link_q[i];
      if (wid_q    == src_id_t'(i)) wid_link  = link_q[i];
    end
  end

  always_comb begin
    logic [11:0] off;
    logic [4:0]  blk;
    int          wsel, pw, cw;
    src_id_t     eid;
    n_en = en_q; n_pend = pend_q; n_act = act_q; n_model = model_q; n_edge = edge_q;
    n_prio = prio_q; n_dist_en = dist_en_q; n_cpu_en = cpu_en_q; n_pmask = pmask_q;
    n_run_id = run_id_q; n_run_prio = run_prio_q;
    n_walk = walk_q; n_wtmp = wtmp_q; n_wid = wid_q;
    rd_val = '0; rd_err = 1'b0; ack_ok = 1'b0; link_we = 1'b0;
    off  = bus_addr[11:0];
    blk  = off[11:7];
    wsel = int'(off[6:2]);
    pw   = int'(off[9:2]);
    cw   = int'(off[7:2]);
    eid  = bus_wdata[ID_W-1:0];
    if (walk_q && (walk_next == ID_NONE || walk_next == wid_q)) n_walk = 1'b0;
    else if (walk_q) n_wtmp = walk_next;
    for (int i = 0; i < NEXT; i++)
      if (rise[i] && (edge_q[32+i] || en_q[32+i])) n_pend[32+i] = 1'b1;
    if (acc && bus_addr[12]) begin
      if (off == 12'h000) begin
        rd_val[0] = dist_en_q;
        if (bus_write) n_dist_en = bus_wdata[0];
      end else if (off == 12'h004) begin
        rd_val = 32'(NWORD - 1);
      end else if (blk >= 5'd2 && blk <= 5'd6 && wsel < NWORD) begin
        if (blk == 5'd6 && bus_write) rd_err = 1'b1;
        for (int i = 0; i < NUM_SRC; i++) begin
          if (i / 32 == wsel) begin
            case (blk)
              5'd2, 5'd3: rd_val[i%32] = en_q[i];
              5'd4, 5'd5: rd_val[i%32] = pend_q[i];
              default:    rd_val[i%32] = act_q[i];
            endcase
            if (bus_write && bus_wdata[i%32]) begin
              case (blk)
                5'd2: begin
                  n_en[i] = 1'b1;
                  if (lvl_all[i] && !edge_q[i]) n_pend[i] = 1'b1;
                end
                5'd3: n_en[i]   = 1'b0;
                5'd4: n_pend[i] = 1'b1;
                5'd5: n_pend[i] = 1'b0;
                default: ;
              endcase
            end
          end
        end
      end else if (off[11:10] == 2'b01 && pw < NPW) begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (i / 4 == pw) begin
            rd_val[8*(i%4) +: 8] = prio_q[i];
            if (bus_write) n_prio[i] = bus_wdata[8*(i%4) +: 8];
          end
        end
      end else if (off[11:10] == 2'b10 && pw < NPW) begin
        rd_val = '0;
      end else if (off[11:8] == 4'hC && cw < NCW) begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (i / 16 == cw) begin
            rd_val[2*(i%16)]   = model_q[i];
            rd_val[2*(i%16)+1] = edge_q[i];
            if (bus_write) begin
              n_model[i] = bus_wdata[2*(i%16)];
              n_edge[i]  = bus_wdata[2*(i%16)+1];
            end
          end
        end
      end else if (off == 12'hF00 && bus_write) begin
        for (int i = 0; i < NUM_SRC; i++)
          if (eid == src_id_t'(i)) n_pend[i] = 1'b1;
      end else begin
        rd_err = 1'b1;
      end
    end else if (acc) begin
      case (off)
        12'h000: begin rd_val[0] = cpu_en_q; if (bus_write) n_cpu_en = bus_wdata[0]; end
        12'h004: begin rd_val[7:0] = pmask_q; if (bus_write) n_pmask = bus_wdata[7:0]; end
        12'h008: ;
        12'h00C: if (!bus_write) begin
          if (hp_id_q != ID_NONE && hp_prio_q < run_prio_q) begin
            ack_ok = 1'b1; link_we = 1'b1;
            rd_val[ID_W-1:0] = hp_id_q;
            n_run_id = hp_id_q; n_run_prio = hp_prio_q;
            for (int i = 0; i < NUM_SRC; i++)
              if (hp_id_q == src_id_t'(i)) begin n_pend[i] = 1'b0; n_act[i] = 1'b1; end
          end else begin
            rd_val[ID_W-1:0] = ID_NONE;
          end
        end
        12'h010: if (!bus_write) rd_err = 1'b1;
          else if (run_id_q != ID_NONE) begin
            for (int i = 0; i < NUM_SRC; i++)
              if (eid == src_id_t'(i)) begin
                n_act[i] = 1'b0;
                if (!edge_q[i] && en_q[i] && lvl_all[i]) n_pend[i] = 1'b1;
                if (eid != run_id_q) begin n_walk = 1'b1; n_wtmp = run_id_q; n_wid = eid; end
              end
            if (eid == run_id_q) begin
              n_run_id   = run_link;
              n_run_prio = PRIO_IDLE;
              for (int i = 0; i < NUM_SRC; i++)
                if (run_link == src_id_t'(i)) n_run_prio = {1'b0, prio_q[i]};
            end
          end
        12'h014: rd_val[PRIO_W:0]  = run_prio_q;
        12'h018: rd_val[ID_W-1:0]  = hp_id_q;
        default: rd_err = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    logic gate;
    if (rst) begin
      en_q <= NUM_SRC'((1 << NBOOT) - 1); edge_q <= NUM_SRC'((1 << NBOOT) - 1);
      pend_q <= '0; act_q <= '0; model_q <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin prio_q[i] <= '0; link_q[i] <= ID_NONE; end
      dist_en_q <= 1'b0; cpu_en_q <= 1'b0; pmask_q <= 8'hF0;
      run_id_q <= ID_NONE; run_prio_q <= PRIO_IDLE;
      hp_id_q <= ID_NONE; hp_prio_q <= PRIO_IDLE; irq_q <= 1'b0;
      dirty_q <= 1'b0; walk_q <= 1'b0; wtmp_q <= ID_NONE; wid_q <= ID_NONE;
      bus_rdata <= '0; bus_rvalid <= 1'b0; bus_err <= 1'b0;
    end else begin
      en_q <= n_en; pend_q <= n_pend; act_q <= n_act; model_q <= n_model; edge_q <= n_edge;
      prio_q <= n_prio; dist_en_q <= n_dist_en; cpu_en_q <= n_cpu_en; pmask_q <= n_pmask;
      run_id_q <= n_run_id; run_prio_q <= n_run_prio;
      walk_q <= n_walk; wtmp_q <= n_wtmp; wid_q <= n_wid;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (link_we && hp_id_q == src_id_t'(i)) link_q[i] <= run_id_q;
        if (walk_q && walk_next == wid_q && walk_next != ID_NONE && wtmp_q == src_id_t'(i))
          link_q[i] <= wid_link;
      end
      gate      = dist_en_q && cpu_en_q && (best_prio <= {1'b0, pmask_q});
      hp_id_q   <= gate ? best_id : ID_NONE;
      hp_prio_q <= gate ? best_prio : PRIO_IDLE;
      irq_q     <= gate && (best_prio < run_prio_q) && !ack_ok;
      dirty_q   <= acc || (|rise) || (|fall) || walk_q;
      bus_rdata  <= (acc && !bus_write && !rd_err) ? rd_val : '0;
      bus_rvalid <= acc && !bus_write;
      bus_err    <= acc && rd_err;
    end
  end
endmodule

// File: rtl/nest_intc_checker.sv
module nest_intc_checker
  import nest_intc_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_valid,
  input logic        bus_write,
  input logic        bus_ready,
  input logic        bus_rvalid,
  input logic        bus_err,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic        dist_en,
  input logic        cpu_en,
  input src_id_t     run_id,
  input rprio_t      run_prio,
  input src_id_t     hp_id,
  input logic        walking
);
  // R13: one stall cycle follows every accepted access
  a_r13_stall_after_access: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_ready) |=> !bus_ready);
  // R13: read data only after an accepted read
  a_r13_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_valid && bus_ready && !bus_write));
  // R7: the bus is held off while the chain is being walked
  a_r7_walk_blocks_bus: assert property (@(posedge clk) disable iff (rst)
    walking |-> !bus_ready);
  // R12: an error response carries zero data
  a_r12_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == 32'h0));
  // R3: request only from a state with both enables on
  a_r3_irq_needs_enables: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(dist_en && cpu_en));
  // R6: an idle running ID goes with the idle priority
  a_r6_idle_priority: assert property (@(posedge clk) disable iff (rst)
    (run_id == ID_NONE) |-> (run_prio == PRIO_IDLE));
  // R2: the highest pending ID is a real source or none
  a_r2_hp_in_range: assert property (@(posedge clk) disable iff (rst)
    (hp_id != ID_NONE) |-> (int'(hp_id) < NUM_SRC));
endmodule

bind nest_intc nest_intc_checker #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_ready(bus_ready), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
  .bus_rdata(bus_rdata), .irq(irq_o), .dist_en(dist_en_q), .cpu_en(cpu_en_q),
  .run_id(run_id_q), .run_prio(run_prio_q), .hp_id(hp_id_q), .walking(walk_q));

// File: tb/nest_intc_tb_top.sv
module nest_intc_tb_top;
  localparam int NUM_SRC = 96;
  localparam logic [31:0] NONE = 32'd1023;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, bus_rvalid, bus_err, irq_o;
  logic [31:0] bus_rdata;
  logic [NUM_SRC-33:0] ext_irq = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic last_err, last_rdy;

  always #2.5 clk = ~clk;

  nest_intc #(.NUM_SRC(NUM_SRC)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
    .ext_irq(ext_irq), .irq_o(irq_o));

  function automatic logic [31:0] pf(input int i);
    return 32'(((i * 7) % 16) * 16);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic acc_bus(input logic w, input logic [12:0] a, input logic [31:0] d,
                         output logic [31:0] q);
    @(negedge clk);
    while (!bus_ready) @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    q = bus_rdata; last_err = bus_err; last_rdy = bus_ready;
    @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    logic [31:0] q;
    acc_bus(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] q);
    acc_bus(1'b0, a, 32'h0, q);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    rd(13'h018, v); chk("R1 highest pending", v, NONE);
    rd(13'h014, v); chk("R1 running prio", v, 32'h100);
    rd(13'h004, v); chk("R1 mask", v, 32'hF0);
    rd(13'h000, v); chk("R1 cpu enable", v, 32'h0);
    rd(13'h1004, v); chk("R1 type", v, 32'(NUM_SRC / 32 - 1));
    rd(13'h1100, v); chk("R1 boot enables", v, 32'h00007FFF);
    rd(13'h1C00, v); chk("R1 boot edge cfg", v, 32'h2AAAAAAA);
    // R13: stall after access
    chk("R13 ready low after access", {31'b0, last_rdy}, 32'h0);

    wr(13'h1000, 1); wr(13'h000, 1); wr(13'h004, 32'hFF);
    for (int w = 0; w < NUM_SRC / 4; w++)
      wr(13'(32'h1400 + 4 * w), {pf(4*w+3)[7:0], pf(4*w+2)[7:0], pf(4*w+1)[7:0], pf(4*w)[7:0]});
    rd(13'h1428, v); chk("R11 priority bytes", v, {pf(43)[7:0], pf(42)[7:0], pf(41)[7:0], pf(40)[7:0]});
    rd(13'h1800, v); chk("R11 target zero", v, 32'h0);

    // R2: every source alone
    for (int k = 0; k < NUM_SRC; k++) begin
      wr(13'(32'h1100 + 4 * (k / 32)), 32'h1 << (k % 32));
      wr(13'(32'h1200 + 4 * (k / 32)), 32'h1 << (k % 32));
      rd(13'h018, v); chk("R2 single source", v, 32'(k));
      rd(13'(32'h1200 + 4 * (k / 32)), v); chk("R11 pending bit", v, 32'h1 << (k % 32));
      wr(13'(32'h1280 + 4 * (k / 32)), 32'h1 << (k % 32));
    end
    // R2: every pair in 32..47, ties to lowest ID
    for (int a = 32; a < 48; a++)
      for (int b = a + 1; b < 48; b++) begin
        wr(13'h1204, (32'h1 << (a - 32)) | (32'h1 << (b - 32)));
        rd(13'h018, v);
        chk("R2 pair winner", v, (pf(b) < pf(a)) ? 32'(b) : 32'(a));
        wr(13'h1284, 32'hFFFFFFFF);
      end
    wr(13'h1180, 32'hFFFFFFFF); wr(13'h1184, 32'hFFFFFFFF); wr(13'h1188, 32'hFFFFFFFF);
    rd(13'h1104, v); chk("R11 clear enable", v, 32'h0);

    // R3: mask and enables gate the request; source 40 has priority 0x80
    wr(13'h1104, 32'h100); wr(13'h1204, 32'h100);
    wr(13'h004, 32'h7F);
    chk("R3 irq masked", {31'b0, irq_o}, 32'h0);
    rd(13'h018, v); chk("R2 masked none", v, NONE);
    wr(13'h004, 32'h80);
    chk("R3 irq at mask", {31'b0, irq_o}, 32'h1);
    wr(13'h1000, 0);
    chk("R3 irq dist off", {31'b0, irq_o}, 32'h0);
    rd(13'h018, v); chk("R2 dist off none", v, NONE);
    wr(13'h1000, 1);
    chk("R3 irq back", {31'b0, irq_o}, 32'h1);

    // R5: acknowledge
    rd(13'h00C, v); chk("R5 ack id", v, 32'd40);
    chk("R5 irq dropped", {31'b0, irq_o}, 32'h0);
    rd(13'h014, v); chk("R5 running prio", v, 32'h80);
    rd(13'h1204, v); chk("R5 pending cleared", v, 32'h0);
    rd(13'h1304, v); chk("R5 active set", v, 32'h100);
    rd(13'h00C, v); chk("R5 ack none", v, NONE);

    // R6: nest 33 (0x70) over 40, complete in order
    wr(13'h1104, 32'h2); wr(13'h1204, 32'h2);
    chk("R3 irq preempt", {31'b0, irq_o}, 32'h1);
    rd(13'h00C, v); chk("R5 ack nested", v, 32'd33);
    rd(13'h014, v); chk("R5 nested prio", v, 32'h70);
    wr(13'h010, 33);
    rd(13'h014, v); chk("R6 predecessor prio", v, 32'h80);
    rd(13'h1304, v); chk("R6 active after eoi", v, 32'h100);

    // R7: nest again, complete the outer one first
    wr(13'h1204, 32'h2);
    rd(13'h00C, v); chk("R5 ack nested again", v, 32'd33);
    wr(13'h1104, 32'h1 << 24); wr(13'h1204, 32'h1 << 24);
    rd(13'h00C, v); chk("R5 not better gives none", v, NONE);
    rd(13'h018, v); chk("R2 hp while running", v, 32'd56);
    wr(13'h1284, 32'h1 << 24);
    wr(13'h010, 40);
    rd(13'h014, v); chk("R7 running kept", v, 32'h70);
    rd(13'h1304, v); chk("R7 active of unlinked", v, 32'h2);
    wr(13'h010, 33);
    rd(13'h014, v); chk("R7 chain skips unlinked", v, 32'h100);

    // R8: completion while idle
    wr(13'h1204, 32'h100);
    wr(13'h010, 40);
    rd(13'h1204, v); chk("R8 pending kept", v, 32'h100);
    rd(13'h014, v); chk("R8 running idle", v, 32'h100);
    wr(13'h1284, 32'hFFFFFFFF);

    // R4, R9, R10: level source 34 on ext bit 2 (priority 0xE0)
    wr(13'h1184, 32'hFFFFFFFF); wr(13'h004, 32'hFF);
    ext_irq[2] = 1'b1;
    rd(13'h1204, v); chk("R4 disabled level no pend", v, 32'h0);
    wr(13'h1104, 32'h4);
    rd(13'h1204, v); chk("R10 enable high level pends", v, 32'h4);
    rd(13'h00C, v); chk("R5 ack level", v, 32'd34);
    rd(13'h1204, v); chk("R5 level pend cleared", v, 32'h0);
    wr(13'h010, 34);
    rd(13'h1204, v); chk("R9 level repend", v, 32'h4);
    ext_irq[2] = 1'b0;
    rd(13'h1204, v); chk("R4 fall keeps pending", v, 32'h4);
    wr(13'h1284, 32'hFFFFFFFF); wr(13'h1184, 32'hFFFFFFFF);

    // R4: edge source 35 on ext bit 3, disabled
    wr(13'h1C08, 32'h80);
    rd(13'h1C08, v); chk("R11 cfg readback", v, 32'h80);
    ext_irq[3] = 1'b1;
    rd(13'h1204, v); chk("R4 edge rise pends", v, 32'h8);
    wr(13'h1284, 32'h8);
    ext_irq[3] = 1'b0;
    rd(13'h1204, v); chk("R4 edge fall no pend", v, 32'h0);
    ext_irq[3] = 1'b1;
    rd(13'h1204, v); chk("R4 edge second rise", v, 32'h8);

    // R11: software trigger word
    wr(13'h1F00, 70);
    rd(13'h1208, v); chk("R11 trigger word", v, 32'h40);

    // R12: unmapped offsets
    rd(13'h1380, v); chk("R12 data zero", v, 32'h0);
    chk("R12 err raised", {31'b0, last_err}, 32'h1);
    rd(13'h0020, v); chk("R12 cpu unmapped err", {31'b0, last_err}, 32'h1);
    rd(13'h018, v); chk("R12 mapped no err", {31'b0, last_err}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule